// File: doc/BRIEF.md
# Fast-to-Slow Bus Bridge

This block sits between a fast on-board CPU bus and a slow 8-bit external system bus whose timing is set by a slow two-phase clock. Each CPU access is decoded by its upper address bits. An access to the slow bank is carried out on the system bus, and all other accesses are left to on-board memory and run at full speed. While an access to the slow bus is in progress, the block stretches the CPU with a wait output. It then returns read data, or drives write data through the transceiver.

The external address and read/write lines are registered. They move only at the falling edge of the slow clock's high phase, which ends one slow cycle and starts the next. When no slow access is in progress, they rest at address zero with read selected. A request that arrives part-way through a slow cycle waits for the next cycle start. The bridge serves only one slow access at a time.

The slow clock is assumed to be synchronous to the fast clock. Its edges are detected by one register in the fast domain.

Top module: `fastslow_bridge`

## Requirements
- R1: Reset is asynchronous and active low. During and after reset, sys_addr is 0, sys_rw is 1 (read), xcvr_en is 0 and cpu_wait is 0.
- R2: A request whose address bank (cpu_addr[23:16]) differs from SLOW_BANK (default 0) never raises cpu_wait. It leaves sys_addr at 0 and sys_rw at 1, and it keeps xcvr_en at 0.
- R3: A request to the slow bank raises cpu_wait in the same clock. cpu_wait stays high until the slow cycle that carries the access has ended.
- R4: sys_addr and sys_rw change only on the clock edge at which the sampled slow clock goes from 1 to 0 (the cycle boundary). They never change anywhere else in the slow cycle.
- R5: At the boundary that starts the access, sys_addr takes cpu_addr[15:0] and sys_rw takes the inverse of cpu_we.
- R6: A slow request that is present in the boundary clock itself starts at that boundary. Otherwise it is held until the next boundary. With a slow cycle of 8 clocks, 4 low then 4 high, and the request first seen k clocks after a boundary clock (k = 0..7), the number of clocks with cpu_wait high is 9 for k = 0 and 17 − k otherwise.
- R7: At the boundary that ends the access, sys_addr returns to 0 and sys_rw returns to 1. cpu_wait is then low for one clock, and for a read cpu_rdata holds the sys_din value sampled at that boundary.
- R8: For a write, xcvr_en is 1 and xcvr_dir is 1 (CPU toward system) for the whole high phase of the access cycle, and sys_dout equals the CPU write data.
- R9: For a read, xcvr_en is 1 with xcvr_dir 0 during the high phase of the access cycle. xcvr_en is 0 at all other times, which gives 4 enabled clocks per access.
- R10: Only one slow access runs at a time. A new request presented right after an acknowledge waits for the next boundary and takes a full slow cycle of its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU access valid |
| cpu_we | input | 1 | CPU write (1) or read (0) |
| cpu_addr | input | 24 | CPU address; bits 23:16 select the bank |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Data returned from a slow read |
| cpu_wait | output | 1 | Stretch request to the CPU |
| sys_phi2 | input | 1 | Slow bus clock, high phase is the data phase |
| sys_addr | output | 16 | Registered system-bus address |
| sys_rw | output | 1 | Registered system-bus read (1) / write (0) |
| sys_dout | output | 8 | Write data toward the transceiver |
| sys_din | input | 8 | Read data from the transceiver |
| xcvr_en | output | 1 | Transceiver enable |
| xcvr_dir | output | 1 | Transceiver direction, 1 = CPU to system |

## Verification
The arrival of a slow request and a slow-cycle boundary can land in the same clock. In that clock the bridge has to choose between starting the access at once and arming it for the following boundary. The bench presents requests at every relevant phase of the slow cycle, including the boundary clock itself. It judges each request by the exact count of stretched clocks and by checking that the address moved only at boundary clocks. The acknowledge of one access and the presentation of the next also fall next to a boundary. A back-to-back request checks that the second access is not folded into the first access's cycle.

// File: rtl/fsb_pkg.sv
package fsb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_ACTIVE = 2'd2,
    ST_ACK    = 2'd3
  } seq_state_e;
endpackage

// File: rtl/fsb_phase_det.sv
module fsb_phase_det (
  input  logic clk,
  input  logic rst_n,
  input  logic phi2,
  output logic boundary
);
  logic phi2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phi2_q <= 1'b0;
    else        phi2_q <= phi2;
  end

  // slow cycle ends when the high phase falls
  assign boundary = phi2_q & ~phi2;
endmodule

// File: rtl/fsb_seq.sv
module fsb_seq
  import fsb_pkg::*;
#(
  parameter int CPU_AW = 24,
  parameter int SYS_AW = 16,
  localparam int BANK_W = CPU_AW - SYS_AW,
  parameter logic [BANK_W-1:0] SLOW_BANK = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic              boundary,
  output logic              load,
  output logic              finish,
  output logic              active,
  output logic              ack,
  output logic              cpu_wait
);
  function automatic logic hits_slow(input logic [CPU_AW-1:0] a);
    return a[CPU_AW-1 -: BANK_W] == SLOW_BANK;
  endfunction

  seq_state_e state, state_nx;
  logic slow_req;

  assign slow_req = cpu_req & hits_slow(cpu_addr);

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:   if (slow_req) state_nx = boundary ? ST_ACTIVE : ST_ARMED;
      ST_ARMED:  if (!slow_req)    state_nx = ST_IDLE;
                 else if (boundary) state_nx = ST_ACTIVE;
      ST_ACTIVE: if (boundary) state_nx = ST_ACK;
      ST_ACK:    state_nx = ST_IDLE;
      default:   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  assign load     = boundary & slow_req & ((state == ST_IDLE) | (state == ST_ARMED));
  assign finish   = boundary & (state == ST_ACTIVE);
  assign active   = (state == ST_ACTIVE);
  assign ack      = (state == ST_ACK);
  assign cpu_wait = slow_req & ~ack;

  AST_ACK_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(boundary)); // R7

  AST_LOAD_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> active); // R10
endmodule

// File: rtl/fsb_sysregs.sv
module fsb_sysregs #(
  parameter int SYS_AW = 16,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              finish,
  input  logic [SYS_AW-1:0] req_addr,
  input  logic              req_we,
  input  logic [DW-1:0]     req_wdata,
  input  logic [DW-1:0]     sys_din,
  output logic [SYS_AW-1:0] sys_addr,
  output logic              sys_rw,
  output logic [DW-1:0]     sys_dout,
  output logic [DW-1:0]     cpu_rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_addr  <= '0;
      sys_rw    <= 1'b1;
      sys_dout  <= '0;
      cpu_rdata <= '0;
    end else if (load) begin
      sys_addr <= req_addr;
      sys_rw   <= ~req_we;
      sys_dout <= req_wdata;
    end else if (finish) begin
      if (sys_rw) cpu_rdata <= sys_din;
      sys_addr <= '0;
      sys_rw   <= 1'b1;
    end
  end

  AST_LOAD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (sys_addr == $past(req_addr)) && (sys_rw == !$past(req_we))); // R5

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && finish)); // R10
endmodule

// File: rtl/fsb_xcvr_ctl.sv
module fsb_xcvr_ctl (
  input  logic active,
  input  logic phi2,
  input  logic sys_rw,
  output logic xcvr_en,
  output logic xcvr_dir
);
  assign xcvr_en  = active & phi2;
  assign xcvr_dir = ~sys_rw;
endmodule

// File: rtl/fastslow_bridge.sv
module fastslow_bridge #(
  parameter int CPU_AW = 24,
  parameter int SYS_AW = 16,
  parameter int DW     = 8,
  localparam int BANK_W = CPU_AW - SYS_AW,
  parameter logic [BANK_W-1:0] SLOW_BANK = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  output logic [DW-1:0]     cpu_rdata,
  output logic              cpu_wait,
  input  logic              sys_phi2,
  output logic [SYS_AW-1:0] sys_addr,
  output logic              sys_rw,
  output logic [DW-1:0]     sys_dout,
  input  logic [DW-1:0]     sys_din,
  output logic              xcvr_en,
  output logic              xcvr_dir
);
  logic boundary, load, finish, active, ack;

  fsb_phase_det u_phase (
    .clk(clk), .rst_n(rst_n), .phi2(sys_phi2), .boundary(boundary)
  );

  fsb_seq #(.CPU_AW(CPU_AW), .SYS_AW(SYS_AW), .SLOW_BANK(SLOW_BANK)) u_seq (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
    .boundary(boundary), .load(load), .finish(finish), .active(active),
    .ack(ack), .cpu_wait(cpu_wait)
  );

  fsb_sysregs #(.SYS_AW(SYS_AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .load(load), .finish(finish),
    .req_addr(cpu_addr[SYS_AW-1:0]), .req_we(cpu_we), .req_wdata(cpu_wdata),
    .sys_din(sys_din), .sys_addr(sys_addr), .sys_rw(sys_rw),
    .sys_dout(sys_dout), .cpu_rdata(cpu_rdata)
  );

  fsb_xcvr_ctl u_xcvr (
    .active(active), .phi2(sys_phi2), .sys_rw(sys_rw),
    .xcvr_en(xcvr_en), .xcvr_dir(xcvr_dir)
  );

  AST_ADDR_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(sys_addr) && $stable(sys_rw)) |-> $past(boundary)); // R4

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (sys_addr == '0) && sys_rw); // R7

  AST_DIR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (xcvr_en && xcvr_dir) |-> !sys_rw); // R8

  AST_XCVR_IN_PHI2: assert property (@(posedge clk) disable iff (!rst_n)
    xcvr_en |-> sys_phi2 && !ack); // R9
endmodule

// File: tb/fastslow_bridge_tb.sv
module fastslow_bridge_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [23:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0, sys_din = '0;
  logic        sys_phi2 = 1'b0;
  logic [7:0]  cpu_rdata, sys_dout;
  logic        cpu_wait, sys_rw, xcvr_en, xcvr_dir;
  logic [15:0] sys_addr;

  int total = 0, bad = 0, tcount = 0;
  logic [15:0] prev_addr = '0;
  logic        prev_rw = 1'b1;

  always #2 clk = ~clk;

  fastslow_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_wait(cpu_wait), .sys_phi2(sys_phi2), .sys_addr(sys_addr),
    .sys_rw(sys_rw), .sys_dout(sys_dout), .sys_din(sys_din),
    .xcvr_en(xcvr_en), .xcvr_dir(xcvr_dir)
  );

  // {addr[24], we, wdata[8], din[8], phase[3], exp_wait[5]}
  localparam logic [48:0] VEC [6] = '{
    {24'h00_1234, 1'b0, 8'h00, 8'hA5, 3'd3, 5'd14},
    {24'h00_BEEF, 1'b1, 8'h3C, 8'h00, 3'd0, 5'd9},
    {24'h00_0000, 1'b0, 8'h00, 8'h5A, 3'd2, 5'd15},
    {24'h00_FFFF, 1'b1, 8'hC3, 8'h00, 3'd7, 5'd10},
    {24'h00_8001, 1'b0, 8'h00, 8'hFF, 3'd4, 5'd13},
    {24'h00_0001, 1'b1, 8'h00, 8'h00, 3'd1, 5'd16}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic begin_tick();
    @(negedge clk);
    sys_phi2 = (tcount % 8) >= 4;
  endtask

  task automatic end_tick();
    #1;
    if (rst_n && (sys_addr !== prev_addr || sys_rw !== prev_rw))
      check((tcount % 8) == 1, "R4 change off boundary", tcount % 8, 1);
    prev_addr = sys_addr;
    prev_rw   = sys_rw;
    tcount++;
  endtask

  task automatic run_txn(input logic [48:0] v);
    int waits = 0, en_ticks = 0;
    bit done = 0;
    logic [23:0] a = v[48:25];
    logic we = v[24];
    while ((tcount % 8) != int'(v[7:5])) begin begin_tick(); end_tick(); end
    while (!done && waits < 40) begin
      begin_tick();
      cpu_req = 1'b1; cpu_addr = a; cpu_we = we; cpu_wdata = v[23:16]; sys_din = v[15:8];
      end_tick();
      if (xcvr_en) begin
        en_ticks++;
        check(sys_addr == a[15:0] && sys_rw == !we, "R5 addr/rw during access",
              {sys_rw, sys_addr}, {!we, a[15:0]});
        if (we) check(xcvr_dir && sys_dout == v[23:16], "R8 write drive", {xcvr_dir, sys_dout}, {1'b1, v[23:16]});
        else    check(!xcvr_dir, "R9 read direction", xcvr_dir, 0);
      end
      if (cpu_wait) waits++;
      else done = 1;
    end
    check(waits == int'(v[4:0]), "R3/R6 stretch length", waits, v[4:0]);
    check(en_ticks == 4, "R9 enabled clocks", en_ticks, 4);
    check(sys_addr == 16'h0 && sys_rw, "R7 neutral after access", {sys_rw, sys_addr}, 17'h10000);
    if (!we) check(cpu_rdata == v[15:8], "R7 read data", cpu_rdata, v[15:8]);
    begin_tick(); cpu_req = 1'b0; end_tick();
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) begin begin_tick(); end_tick(); end
    check(sys_addr == 0 && sys_rw && !xcvr_en && !cpu_wait, "R1 reset state",
          {xcvr_en, cpu_wait, sys_rw, sys_addr}, 19'h10000);
    begin_tick(); rst_n = 1'b1; end_tick();

    // R2: fast bank over a full slow cycle
    for (int i = 0; i < 10; i++) begin
      begin_tick(); cpu_req = 1'b1; cpu_addr = 24'h12_3456; cpu_we = 1'b1; end_tick();
      check(!cpu_wait && !xcvr_en && sys_addr == 0 && sys_rw, "R2 fast access",
            {cpu_wait, xcvr_en, sys_rw, sys_addr}, 19'h10000);
    end
    begin_tick(); cpu_req = 1'b0; end_tick();

    // vector table: phases incl. boundary clock (R6), back-to-back (R10)
    for (int k = 0; k < 6; k++) run_txn(VEC[k]);

    // R10: request right after an acknowledge gets its own full cycle
    run_txn({24'h00_2222, 1'b0, 8'h00, 8'h77, 3'd2, 5'd15});

    // R1: reset in the middle of an active high phase
    while ((tcount % 8) != 0) begin begin_tick(); end_tick(); end
    for (int i = 0; i < 6; i++) begin
      begin_tick(); cpu_req = 1'b1; cpu_addr = 24'h00_4321; cpu_we = 1'b1; end_tick();
    end
    check(xcvr_en == 1'b1, "R8 enable before reset", xcvr_en, 1);
    begin_tick(); rst_n = 1'b0; end_tick();
    check(sys_addr == 0 && sys_rw && !xcvr_en, "R1 reset mid-access",
          {xcvr_en, sys_rw, sys_addr}, 18'h10000);
    begin_tick(); cpu_req = 1'b0; end_tick();
    check(!cpu_wait, "R1 wait low after reset", cpu_wait, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule